// File: doc/BRIEF.md
# Two-Section Translation Lookup Unit

This block searches a translation table for a virtual address and reports whether an entry covers it and, if so, which slot holds that entry. The table has two sections. The first is set-associative: 8 ways of 256 sets. All of its entries share one page size, which comes from an input. The second section has 64 entries, and each of those entries carries its own page-size field. All 64 entries are compared at once. Each entry maps a pair of adjacent pages, one even and one odd. Its stored tag is the virtual address from bit 13 upward. Before the compare, the bits that fall below the page-pair boundary are dropped from both the address and the stored tag.

A single write port loads entries by slot number. Slots 0 to 2047 address the set-associative section as way × 256 + set. The next 64 slots address the fully associative section. A lookup request is taken in one cycle, and its registered response appears two cycles later. A new request may be issued every cycle. The block does not check access rights and does not choose which slot to replace; both are the surrounding logic's job.

Top module: `tlbl_lookup`

## Requirements
- R1: A request taken with `req_valid` high in cycle n produces `rsp_valid` high in cycle n+2 and in no other cycle. Back-to-back requests each get their own response, in order.
- R2: In the set-associative section the set is bits [ps+8 : ps+1] of the virtual address, where ps is `glb_ps`. A hit there reports slot way × 256 + set.
- R3: With page size ps, a stored tag (virtual bits 47:13) matches when its bits from position ps+1−13 upward equal virtual address bits 47 down to ps+1. Address bits below ps+1 and tag bits below position ps+1−13 do not affect the compare.
- R4: A match needs either the entry's global bit set or the entry's ASID equal to `cur_asid`.
- R5: An entry whose exist bit is clear never matches.
- R6: When both sections match, the set-associative hit is reported.
- R7: Within one section, the matching way or entry with the lowest number is reported.
- R8: Fully associative entry e is reported as slot 2048 + e. It uses its own stored page size for the compare, in place of `glb_ps`.
- R9: A lookup sees the table as it stood before any write presented in the same cycle as its request. That write takes effect for requests in later cycles.
- R10: A write to a slot number of 2112 or above changes no entry.
- R11: After reset, every entry is absent and `rsp_valid` is low. When a response reports a miss, `rsp_hit` is 0 and `rsp_idx` is 0.

Page sizes used with the block must lie between 12 and 37.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| glb_ps | input | 6 | Page size (log2 bytes) shared by the set-associative section |
| cur_asid | input | 10 | Address-space identifier of the current context |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | 12 | Slot to write |
| wr_exist | input | 1 | Exist bit to store |
| wr_global | input | 1 | Global bit to store |
| wr_asid | input | 10 | ASID to store |
| wr_tag | input | 35 | Virtual address bits 47:13 to store as the tag |
| wr_ps | input | 6 | Page size to store (used by the fully associative section only) |
| req_valid | input | 1 | Lookup request |
| req_va | input | 48 | Virtual address to look up |
| rsp_valid | output | 1 | Response valid, two cycles after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | 12 | Slot of the reported entry, 0 on a miss |

## Verification
Corrupted entry storage or a wrong compare shift shows up at the ports as a wrong `rsp_hit` or a wrong `rsp_idx`. It appears on the first lookup that touches the affected slot, exactly two cycles after that request. A broken priority order appears only when several entries match at once, so the bench loads duplicate tags both within each section and across the two sections. A fault in the pipeline valid path shows as `rsp_valid` shifted by a cycle or missing, and it is visible on every request.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
   // Lowest virtual address bit held in a stored tag.
   localparam int unsigned TLBL_TAG_LO = 13;
   // Smallest page size (log2) the compare logic accepts.
   localparam int unsigned TLBL_MIN_PS = 12;
endpackage

// File: rtl/tlbl_tag_cmp.sv
module tlbl_tag_cmp
   import tlbl_pkg::*;
#(
   parameter int unsigned TAG_W  = 35,
   parameter int unsigned ASID_W = 10,
   parameter int unsigned PS_W   = 6
) (
   input  logic [TAG_W-1:0]  va_tag,
   input  logic [PS_W-1:0]   ps,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              ent_exist,
   input  logic              ent_global,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic [TAG_W-1:0]  ent_tag,
   output logic              hit
);
   logic [PS_W-1:0]  shamt;
   logic [TAG_W-1:0] keep;

   // Tag bits below the page-pair boundary are ignored on both sides.
   always_comb begin
      shamt = ps + PS_W'(1) - PS_W'(TLBL_TAG_LO);
      keep  = {TAG_W{1'b1}} << shamt;
      hit   = ent_exist
              && (ent_global || (ent_asid == cur_asid))
              && (((va_tag ^ ent_tag) & keep) == '0);
   end
endmodule

// File: rtl/tlbl_first_one.sv
module tlbl_first_one #(
   parameter int unsigned N  = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] pos
);
   always_comb begin
      found = |vec;
      pos   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) pos = IW'(i);
      end
   end
endmodule

// File: rtl/tlbl_sa_bank.sv
module tlbl_sa_bank #(
   parameter int unsigned WAYS     = 8,
   parameter int unsigned SET_BITS = 8,
   parameter int unsigned TAG_W    = 35,
   parameter int unsigned ASID_W   = 10,
   parameter int unsigned PS_W     = 6,
   localparam int unsigned SETS    = 1 << SET_BITS,
   localparam int unsigned WAY_W   = $clog2(WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WAY_W-1:0]    wr_way,
   input  logic [SET_BITS-1:0] wr_set,
   input  logic                wr_exist,
   input  logic                wr_global,
   input  logic [ASID_W-1:0]   wr_asid,
   input  logic [TAG_W-1:0]    wr_tag,
   input  logic [SET_BITS-1:0] lk_set,
   input  logic [TAG_W-1:0]    lk_tag,
   input  logic [PS_W-1:0]     lk_ps,
   input  logic [ASID_W-1:0]   lk_asid,
   output logic [WAYS-1:0]     hit_vec
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]   ex_q;
      logic              gl_q   [SETS];
      logic [ASID_W-1:0] asid_q [SETS];
      logic [TAG_W-1:0]  tag_q  [SETS];
      logic              sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ex_q <= '0;
         else if (sel) ex_q[wr_set] <= wr_exist;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            gl_q[wr_set]   <= wr_global;
            asid_q[wr_set] <= wr_asid;
            tag_q[wr_set]  <= wr_tag;
         end
      end

      tlbl_tag_cmp #(.TAG_W(TAG_W), .ASID_W(ASID_W), .PS_W(PS_W)) u_cmp (
         .va_tag    (lk_tag),
         .ps        (lk_ps),
         .cur_asid  (lk_asid),
         .ent_exist (ex_q[lk_set]),
         .ent_global(gl_q[lk_set]),
         .ent_asid  (asid_q[lk_set]),
         .ent_tag   (tag_q[lk_set]),
         .hit       (hit_vec[w])
      );
   end
endmodule

// File: rtl/tlbl_fa_array.sv
module tlbl_fa_array #(
   parameter int unsigned N      = 64,
   parameter int unsigned TAG_W  = 35,
   parameter int unsigned ASID_W = 10,
   parameter int unsigned PS_W   = 6,
   localparam int unsigned SW    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_slot,
   input  logic              wr_exist,
   input  logic              wr_global,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PS_W-1:0]   wr_ps,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [ASID_W-1:0] lk_asid,
   output logic [N-1:0]      hit_vec
);
   for (genvar e = 0; e < N; e++) begin : g_ent
      logic              ex_q;
      logic              gl_q;
      logic [ASID_W-1:0] asid_q;
      logic [TAG_W-1:0]  tag_q;
      logic [PS_W-1:0]   ps_q;
      logic              sel;

      assign sel = wr_en && (wr_slot == SW'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ex_q <= 1'b0;
         else if (sel) ex_q <= wr_exist;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            gl_q   <= wr_global;
            asid_q <= wr_asid;
            tag_q  <= wr_tag;
            ps_q   <= wr_ps;
         end
      end

      // Each entry shifts its compare by its own page size.
      tlbl_tag_cmp #(.TAG_W(TAG_W), .ASID_W(ASID_W), .PS_W(PS_W)) u_cmp (
         .va_tag    (lk_tag),
         .ps        (ps_q),
         .cur_asid  (lk_asid),
         .ent_exist (ex_q),
         .ent_global(gl_q),
         .ent_asid  (asid_q),
         .ent_tag   (tag_q),
         .hit       (hit_vec[e])
      );
   end
endmodule

// File: rtl/tlbl_lookup.sv
module tlbl_lookup
   import tlbl_pkg::*;
#(
   parameter int unsigned VA_W     = 48,
   parameter int unsigned ASID_W   = 10,
   parameter int unsigned PS_W     = 6,
   parameter int unsigned WAYS     = 8,
   parameter int unsigned SET_BITS = 8,
   parameter int unsigned FA_N     = 64,
   localparam int unsigned SETS     = 1 << SET_BITS,
   localparam int unsigned SA_SLOTS = WAYS * SETS,
   localparam int unsigned TOTAL    = SA_SLOTS + FA_N,
   localparam int unsigned IDX_W    = $clog2(TOTAL),
   localparam int unsigned TAG_W    = VA_W - TLBL_TAG_LO,
   localparam int unsigned WAY_W    = $clog2(WAYS),
   localparam int unsigned FA_W     = $clog2(FA_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PS_W-1:0]   glb_ps,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_exist,
   input  logic              wr_global,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PS_W-1:0]   wr_ps,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_idx
);
   // Elaboration-time parameter checks
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0)
      $error("tlbl_lookup: WAYS must be a power of two, at least 2");
   if (FA_N < 2)
      $error("tlbl_lookup: FA_N must be at least 2");
   if (VA_W <= TLBL_TAG_LO + SET_BITS + 1)
      $error("tlbl_lookup: VA_W too small for tag and set fields");

   localparam logic [IDX_W-1:0] SA_BASE  = IDX_W'(SA_SLOTS);
   localparam logic [IDX_W:0]   TOP_SLOT = (IDX_W+1)'(TOTAL);

   // Write decode
   logic               wr_sa, wr_fa;
   logic [WAY_W-1:0]   wr_way;
   logic [SET_BITS-1:0] wr_set;
   logic [FA_W-1:0]    wr_slot;

   always_comb begin
      wr_sa   = wr_en && (wr_idx < SA_BASE);
      wr_fa   = wr_en && (wr_idx >= SA_BASE) && ({1'b0, wr_idx} < TOP_SLOT);
      wr_way  = wr_idx[SET_BITS +: WAY_W];
      wr_set  = wr_idx[SET_BITS-1:0];
      wr_slot = FA_W'(wr_idx - SA_BASE);
   end

   // Lookup: compare against the table as it stands in the request cycle
   logic [SET_BITS-1:0] lk_set;
   logic [TAG_W-1:0]    lk_tag;
   logic [WAYS-1:0]     sa_hit;
   logic [FA_N-1:0]     fa_hit;

   assign lk_set = SET_BITS'(req_va >> (glb_ps + PS_W'(1)));
   assign lk_tag = req_va[VA_W-1:TLBL_TAG_LO];

   tlbl_sa_bank #(
      .WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_W(TAG_W),
      .ASID_W(ASID_W), .PS_W(PS_W)
   ) u_sa (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sa),
      .wr_way   (wr_way),
      .wr_set   (wr_set),
      .wr_exist (wr_exist),
      .wr_global(wr_global),
      .wr_asid  (wr_asid),
      .wr_tag   (wr_tag),
      .lk_set   (lk_set),
      .lk_tag   (lk_tag),
      .lk_ps    (glb_ps),
      .lk_asid  (cur_asid),
      .hit_vec  (sa_hit)
   );

   tlbl_fa_array #(
      .N(FA_N), .TAG_W(TAG_W), .ASID_W(ASID_W), .PS_W(PS_W)
   ) u_fa (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fa),
      .wr_slot  (wr_slot),
      .wr_exist (wr_exist),
      .wr_global(wr_global),
      .wr_asid  (wr_asid),
      .wr_tag   (wr_tag),
      .wr_ps    (wr_ps),
      .lk_tag   (lk_tag),
      .lk_asid  (cur_asid),
      .hit_vec  (fa_hit)
   );

   // Stage 1: registered match vectors
   logic                s1_vld;
   logic [SET_BITS-1:0] s1_set;
   logic [WAYS-1:0]     s1_sa;
   logic [FA_N-1:0]     s1_fa;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_set <= '0;
         s1_sa  <= '0;
         s1_fa  <= '0;
      end else begin
         s1_vld <= req_valid;
         s1_set <= lk_set;
         s1_sa  <= req_valid ? sa_hit : '0;
         s1_fa  <= req_valid ? fa_hit : '0;
      end
   end

   // Stage 2: priority select and registered response
   logic             sa_found, fa_found;
   logic [WAY_W-1:0] sa_pos;
   logic [FA_W-1:0]  fa_pos;
   logic [IDX_W-1:0] nxt_idx;

   tlbl_first_one #(.N(WAYS)) u_sa_pick (.vec(s1_sa), .found(sa_found), .pos(sa_pos));
   tlbl_first_one #(.N(FA_N)) u_fa_pick (.vec(s1_fa), .found(fa_found), .pos(fa_pos));

   always_comb begin
      if (sa_found)      nxt_idx = IDX_W'({sa_pos, s1_set});
      else if (fa_found) nxt_idx = SA_BASE + IDX_W'(fa_pos);
      else               nxt_idx = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_idx   <= '0;
      end else begin
         rsp_valid <= s1_vld;
         rsp_hit   <= s1_vld && (sa_found || fa_found);
         rsp_idx   <= s1_vld ? nxt_idx : '0;
      end
   end
endmodule

module tlbl_lookup_chk #(
   parameter int unsigned VA_W     = 48,
   parameter int unsigned PS_W     = 6,
   parameter int unsigned SET_BITS = 8,
   parameter int unsigned SA_SLOTS = 2048,
   parameter int unsigned TOTAL    = 2112,
   parameter int unsigned IDX_W    = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VA_W-1:0]  req_va,
   input logic [PS_W-1:0]  glb_ps,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic [IDX_W-1:0] rsp_idx
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R1: response follows its request by exactly two cycles
   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

   // R11: miss reports index zero, and a hit only with a valid response
   assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_idx == '0));
   assert_hit_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   // R11: response quiet in the cycle after reset
   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> !rsp_valid);

   // R8: reported slot lies inside the table
   assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> ({1'b0, rsp_idx} < (IDX_W+1)'(TOTAL)));

   // R2: a set-associative hit sits in the set the request addressed
   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc >= 2'd2) && rsp_hit && ({1'b0, rsp_idx} < (IDX_W+1)'(SA_SLOTS)))
      |-> (rsp_idx[SET_BITS-1:0] ==
           SET_BITS'($past(req_va, 2) >> ($past(glb_ps, 2) + PS_W'(1)))));
endmodule

bind tlbl_lookup tlbl_lookup_chk #(
   .VA_W(VA_W), .PS_W(PS_W), .SET_BITS(SET_BITS),
   .SA_SLOTS(SA_SLOTS), .TOTAL(TOTAL), .IDX_W(IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_va   (req_va),
   .glb_ps   (glb_ps),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit),
   .rsp_idx  (rsp_idx)
);

// File: tb/tlbl_lookup_tb.sv
module tlbl_lookup_tb;
   localparam int NSLOT = 2112;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  glb_ps = 6'd12;
   logic [9:0]  cur_asid = '0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_idx = '0;
   logic        wr_exist = 1'b0;
   logic        wr_global = 1'b0;
   logic [9:0]  wr_asid = '0;
   logic [34:0] wr_tag = '0;
   logic [5:0]  wr_ps = '0;
   logic        req_valid = 1'b0;
   logic [47:0] req_va = '0;
   logic        rsp_valid, rsp_hit;
   logic [11:0] rsp_idx;

   always #2 clk = ~clk;

   tlbl_lookup u_dut (
      .clk(clk), .rst_n(rst_n), .glb_ps(glb_ps), .cur_asid(cur_asid),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_exist(wr_exist),
      .wr_global(wr_global), .wr_asid(wr_asid), .wr_tag(wr_tag),
      .wr_ps(wr_ps), .req_valid(req_valid), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
   );

   int  checks = 0;
   int  errs   = 0;
   bit  done   = 1'b0;

   // Shadow of every slot written through the port
   bit         m_ex   [NSLOT];
   bit         m_g    [NSLOT];
   logic [9:0] m_asid [NSLOT];
   logic [34:0] m_tag [NSLOT];
   logic [5:0] m_ps   [NSLOT];

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Reference: page-pair numbers compared after shifting, per requirement
   function automatic void model(input logic [47:0] va, output logic hit,
                                 output logic [11:0] idx);
      logic [47:0] vpn;
      int set, k, s;
      hit = 1'b0; idx = '0;
      vpn = va >> (int'(glb_ps) + 1);
      set = int'(vpn[7:0]);
      s   = int'(glb_ps) + 1 - 13;
      for (int w = 0; w < 8; w++) begin
         k = w * 256 + set;
         if (!hit && m_ex[k] && (m_g[k] || m_asid[k] == cur_asid)
             && vpn == 48'(m_tag[k] >> s)) begin
            hit = 1'b1; idx = 12'(k);
         end
      end
      for (int e = 0; e < 64; e++) begin
         k = 2048 + e;
         if (!hit && m_ex[k] && (m_g[k] || m_asid[k] == cur_asid)
             && (va >> (int'(m_ps[k]) + 1)) == 48'(m_tag[k] >> (int'(m_ps[k]) + 1 - 13))) begin
            hit = 1'b1; idx = 12'(k);
         end
      end
   endfunction

   function automatic void shadow(input int idx, input bit ex, input bit g,
                                  input logic [9:0] a, input logic [34:0] t,
                                  input logic [5:0] p);
      if (idx < NSLOT) begin
         m_ex[idx] = ex; m_g[idx] = g; m_asid[idx] = a;
         m_tag[idx] = t; m_ps[idx] = p;
      end
   endfunction

   task automatic put(input int idx, input bit ex, input bit g,
                      input logic [9:0] a, input logic [34:0] t,
                      input logic [5:0] p);
      wr_en = 1'b1; wr_idx = 12'(idx); wr_exist = ex; wr_global = g;
      wr_asid = a; wr_tag = t; wr_ps = p;
      @(negedge clk);
      wr_en = 1'b0;
      shadow(idx, ex, g, a, t, p);
   endtask

   task automatic look(input logic [47:0] va, input string rq);
      logic eh; logic [11:0] ei;
      model(va, eh, ei);
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R1", 32'(rsp_valid), 32'd1);
      chk({rsp_hit, rsp_idx} == {eh, ei}, rq, 32'({rsp_hit, rsp_idx}), 32'({eh, ei}));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin : main
      logic [47:0] va, va0;
      logic        eh0, eh1, eh2;
      logic [11:0] ei0, ei1, ei2;
      int          set;
      int          plist [6] = '{12, 13, 15, 18, 21, 27};

      for (int i = 0; i < NSLOT; i++) shadow(i, 0, 0, '0, '0, '0);
      repeat (4) @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 reset valid", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 / R5: empty table misses
      look(48'h0000_1234_5000, "R11 empty");
      look(48'hFFFF_0000_0000, "R11 empty");
      look(48'h0000_0000_0000, "R5 empty");

      // R7: all ways hold the same tag, lowest way wins; clear one by one (R5)
      glb_ps = 6'd12;
      va0 = 48'h0000_1234_5000;
      set = int'((va0 >> 13) & 48'hFF);
      for (int w = 0; w < 8; w++) put(w * 256 + set, 1, 1, '0, va0[47:13], 6'd12);
      for (int w = 0; w < 8; w++) begin
         look(va0, "R7 lowest way");
         put(w * 256 + set, 0, 1, '0, va0[47:13], 6'd12);
      end
      look(va0, "R5 all cleared");

      // R2 / R3: sweep of global page sizes
      foreach (plist[i]) begin
         int p;
         p = plist[i];
         glb_ps = 6'(p);
         va = 48'h00C3_5A5A_6000 ^ (48'(i) << 40);
         set = int'((va >> (p + 1)) & 48'hFF);
         put(2 * 256 + set, 1, 1, '0, va[47:13], 6'd12);
         look(va, "R2 hit way2");
         look(va ^ (48'h1 << p), "R3 odd page of pair");
         look(va ^ (48'h1 << (p + 1)), "R2 other set");
         look(va ^ (48'h1 << (p + 9)), "R3 tag bit above set");
         put(2 * 256 + set, 1, 1, '0, va[47:13] ^ 35'h1, 6'd12);
         look(va, "R3 low tag bit ignored");
         put(2 * 256 + set, 0, 1, '0, va[47:13], 6'd12);
      end

      // R4: ASID rule
      glb_ps = 6'd12;
      va = 48'h0000_7777_0000;
      set = int'((va >> 13) & 48'hFF);
      put(set, 1, 0, 10'd5, va[47:13], 6'd12);
      cur_asid = 10'd5; look(va, "R4 asid equal");
      cur_asid = 10'd6; look(va, "R4 asid differ");
      put(set, 1, 1, 10'd5, va[47:13], 6'd12);
      look(va, "R4 global");
      put(set, 0, 1, 10'd5, va[47:13], 6'd12);
      cur_asid = 10'd0;

      // R8: each fully associative entry with its own page size
      for (int e = 0; e < 64; e++) begin
         va = 48'h0A00_0012_3000 | (48'(e) << 30);
         put(2048 + e, 1, 1, '0, va[47:13], 6'(12 + e % 10));
      end
      for (int e = 0; e < 64; e++) begin
         int p;
         p = 12 + e % 10;
         va = 48'h0A00_0012_3000 | (48'(e) << 30);
         look(va, "R8 entry hit");
         look(va ^ (48'h1 << p), "R8 own size pair");
         look(va ^ (48'h1 << (p + 1)), "R8 own size tag");
      end

      // R7 in the fully associative section
      va = 48'h0B00_0000_8000;
      put(2048 + 40, 1, 1, '0, va[47:13], 6'd14);
      put(2048 + 10, 1, 1, '0, va[47:13], 6'd14);
      look(va, "R7 lowest entry");
      // R6: set-associative section wins
      set = int'((va >> 13) & 48'hFF);
      put(5 * 256 + set, 1, 1, '0, va[47:13], 6'd12);
      look(va, "R6 section priority");

      // R10: writes above the table
      va = 48'h0C00_1111_2000;
      put(2112, 1, 1, '0, va[47:13], 6'd12);
      put(4095, 1, 1, '0, va[47:13], 6'd12);
      look(va, "R10 out of range");

      // R9: same-cycle write and request
      va = 48'h0D00_2222_4000;
      set = int'((va >> 13) & 48'hFF);
      model(va, eh0, ei0);
      wr_en = 1'b1; wr_idx = 12'(3 * 256 + set); wr_exist = 1'b1;
      wr_global = 1'b1; wr_asid = '0; wr_tag = va[47:13]; wr_ps = 6'd12;
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      shadow(3 * 256 + set, 1, 1, '0, va[47:13], 6'd12);
      @(negedge clk);
      chk({rsp_valid, rsp_hit, rsp_idx} == {1'b1, eh0, ei0}, "R9 old state",
          32'({rsp_valid, rsp_hit, rsp_idx}), 32'({1'b1, eh0, ei0}));
      look(va, "R9 new state");

      // R1: back-to-back requests
      model(48'h0A00_0012_3000, eh0, ei0);
      model(va, eh1, ei1);
      model(48'h0E00_0000_0000, eh2, ei2);
      req_valid = 1'b1; req_va = 48'h0A00_0012_3000;
      @(negedge clk); req_va = va;
      @(negedge clk); req_va = 48'h0E00_0000_0000;
      chk({rsp_valid, rsp_hit, rsp_idx} == {1'b1, eh0, ei0}, "R1 first",
          32'({rsp_valid, rsp_hit, rsp_idx}), 32'({1'b1, eh0, ei0}));
      @(negedge clk); req_valid = 1'b0;
      chk({rsp_valid, rsp_hit, rsp_idx} == {1'b1, eh1, ei1}, "R1 second",
          32'({rsp_valid, rsp_hit, rsp_idx}), 32'({1'b1, eh1, ei1}));
      @(negedge clk);
      chk({rsp_valid, rsp_hit, rsp_idx} == {1'b1, eh2, ei2}, "R1 third",
          32'({rsp_valid, rsp_hit, rsp_idx}), 32'({1'b1, eh2, ei2}));
      @(negedge clk);
      chk({rsp_valid, rsp_hit, rsp_idx} == 14'd0, "R1 idle",
          32'({rsp_valid, rsp_hit, rsp_idx}), 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule